// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One 16-bit timer channel that counts input clock ticks and shapes a single output line. The count rate comes from a tick enable (`tick_i`), so the channel runs at any rate derived from the system clock. A gate input can pause counting or restart it, depending on the mode. Software selects one of six counting behaviours: terminal-count interrupt, retriggerable one-shot, rate generator, square wave, software strobe and hardware strobe. Software then writes an initial count N.

The channel reports the value a host would read back as the current count. It also reports the output level, the active mode and the sampled gate level. The elapsed-tick reference restarts whenever a count is loaded, and in some modes on a gate rising edge. Every output rule is stated in whole ticks measured from that reference, written d below. Counting is binary only.

Top module: `pit_channel`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `count_o` is 0, `out_o` is 0 and `mode_o` is 0. The channel does not count until a count is loaded.
- R2: In modes 0 and 1, `out_o` is low after a load and goes high in the cycle after the N-th counting tick, when `count_o` reads 0. It then stays high until the next load, mode write or restart.
- R3: In mode 2, `out_o` is high except for one tick interval at each d that is a nonzero multiple of N. During that interval `out_o` is low. `count_o` equals N minus (d mod N), truncated to 16 bits.
- R4: In mode 3, with H = (N+1)/2 and p = d mod N, `out_o` is high while p < H and low otherwise. `count_o` is E-2p in the high phase and E-2(p-H) in the low phase, where E is N with bit 0 cleared, truncated to 16 bits.
- R5: In modes 4 and 5, `out_o` is low except while d equals N exactly. This gives a single tick-long high pulse, during which `count_o` reads 0.
- R6: In modes 0, 1, 4 and 5, `count_o` equals (N - d) mod 2^16. It keeps decrementing and wrapping after terminal count.
- R7: A mode write without a load sets `out_o` to the mode's idle level on the next cycle: high for modes 2 and 3, low otherwise. It also freezes `count_o` at its last value until the next load.
- R8: In modes 0 and 4, a tick while `gate_i` is low is not counted. `count_o` and `out_o` hold, and counting resumes when `gate_i` returns high.
- R9: In modes 1, 2, 3 and 5, a rising edge of `gate_i` (high now, low at the previous clock edge) sets d back to 0 without changing N. In modes 2 and 3 the gate level does not stop counting.
- R10: A loaded value of 0 acts as N = 65536. In mode 0, `out_o` rises only after 65536 counting ticks.
- R11: Mode codes 6 and 7 act as modes 2 and 3, and `mode_o` reports the mapped code. `gate_o` shows `gate_i` as sampled at the previous clock edge.
- R12: A count write (`load_we_i` high) sets d to 0 at that clock edge. On the next cycle `count_o` shows the mode's value for d = 0, which is N in every mode except mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count tick enable, one system clock wide |
| gate_i | input | 1 | Gate level |
| mode_we_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode code to write |
| load_we_i | input | 1 | Initial count write strobe |
| load_val_i | input | CNT_W | Initial count value, 0 meaning 2^CNT_W |
| count_o | output | CNT_W | Current readable count |
| out_o | output | 1 | Shaped timer output |
| mode_o | output | 3 | Active mode |
| gate_o | output | 1 | Registered gate level |

## Verification
The hardest case to reach is the 65536 boundary. It needs a zero load and more than 65536 uninterrupted counting ticks before the output rises and the count wraps. The stimulus loads 0 in mode 0 and holds tick and gate high for 65540 cycles.

Gate restarts partway through a one-shot or strobe are also hard to reach, because they need a gate low/high pair inside the live window. The bench drops the gate for one cycle partway through those windows. It also drops the gate during a terminal-count run in mode 0, to check that counting is suspended. Square-wave phases for odd N are reached by loading 5 through the mode-7 alias.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TC_IRQ    = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } mode_e;

  // codes 6 and 7 alias rate and square
  function automatic mode_e map_mode(input logic [2:0] m);
    logic [2:0] r;
    r = (m[2] & m[1]) ? {1'b0, m[1:0]} : m;
    return mode_e'(r);
  endfunction

  function automatic logic idle_level(input mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic level_gated(input mode_e m);
    return (m == M_TC_IRQ) || (m == M_SW_STROBE);
  endfunction

  function automatic logic edge_restart(input mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HW_STROBE);
  endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       gate_i,
  input  logic       mode_we_i,
  input  logic [2:0] mode_i,
  input  logic       load_we_i,
  output mode_e      mode_o,
  output logic       gate_o,
  output logic       running_o,
  output logic       start_o,
  output logic       count_en_o
);

  mode_e mode_q;
  logic  gate_q;
  logic  run_q;
  logic  restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_TC_IRQ;
      gate_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (mode_we_i) mode_q <= map_mode(mode_i);
      if (load_we_i)      run_q <= 1'b1;
      else if (mode_we_i) run_q <= 1'b0;
    end
  end

  assign restart = run_q & gate_i & ~gate_q & edge_restart(mode_q)
                 & ~load_we_i & ~mode_we_i;

  assign start_o    = load_we_i | restart;
  assign count_en_o = run_q & tick_i & ~start_o & ~mode_we_i
                    & (gate_i | ~level_gated(mode_q));
  assign mode_o     = mode_q;
  assign gate_o     = gate_q;
  assign running_o  = run_q;

  // R11: alias codes land on rate/square
  a_r11_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i && (mode_i[2:1] == 2'b11) |=> (mode_o == mode_e'({1'b0, $past(mode_i[1:0])})));

  // R7: no counting once a mode write stopped the channel
  a_r7_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i && !load_we_i |=> !running_o);

endmodule

// File: rtl/pit_core.sv
module pit_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_we_i,
  input  logic [W-1:0] load_val_i,
  input  logic         start_i,
  input  logic         mode_we_i,
  input  logic         count_en_i,
  input  logic [W-1:0] hold_val_i,
  output logic [W:0]   n_o,
  output logic [W-1:0] cnt_o,
  output logic [W:0]   pos_o,
  output logic         done_o,
  output logic         strobe_o,
  output logic         wrap_o
);

  localparam int NW = W + 1;
  localparam logic [NW-1:0] N_MAX = {1'b1, {W{1'b0}}};

  logic [NW-1:0] n_q, load_n, n_eff, pos_q;
  logic [W-1:0]  cnt_q;
  logic          done_q, strobe_q, wrap_q, last;

  assign load_n = (load_val_i == '0) ? N_MAX : {1'b0, load_val_i};
  assign n_eff  = load_we_i ? load_n : n_q;
  assign last   = (pos_q == n_q - NW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q      <= N_MAX;
      cnt_q    <= '0;
      pos_q    <= '0;
      done_q   <= 1'b0;
      strobe_q <= 1'b0;
      wrap_q   <= 1'b0;
    end else begin
      if (load_we_i) n_q <= load_n;
      if (start_i) begin
        cnt_q    <= n_eff[W-1:0];
        pos_q    <= '0;
        done_q   <= 1'b0;
        strobe_q <= 1'b0;
        wrap_q   <= 1'b0;
      end else if (mode_we_i) begin
        cnt_q    <= hold_val_i;
        strobe_q <= 1'b0;
        wrap_q   <= 1'b0;
      end else if (count_en_i) begin
        cnt_q    <= cnt_q - W'(1);
        strobe_q <= (cnt_q == W'(1)) & ~done_q;
        if (cnt_q == W'(1)) done_q <= 1'b1;
        pos_q    <= last ? '0 : pos_q + NW'(1);
        wrap_q   <= last;
      end
    end
  end

  assign n_o      = n_q;
  assign cnt_o    = cnt_q;
  assign pos_o    = pos_q;
  assign done_o   = done_q;
  assign strobe_o = strobe_q;
  assign wrap_o   = wrap_q;

  // R3/R4: period position always inside the period
  a_r3_pos_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < n_q);

  // R10: zero load selects the full range
  a_r10_zero_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i && (load_val_i == '0) |=> (n_q == N_MAX));

endmodule

// File: rtl/pit_shaper.sv
module pit_shaper
  import pit_pkg::*;
#(
  parameter int W = 16
) (
  input  mode_e        mode_i,
  input  logic         running_i,
  input  logic [W:0]   n_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W:0]   pos_i,
  input  logic         done_i,
  input  logic         strobe_i,
  input  logic         wrap_i,
  output logic         out_o,
  output logic [W-1:0] count_o
);

  localparam int NW = W + 1;

  logic [NW-1:0] half, even_n, rate_cnt, sq_hi, sq_lo;
  logic          hi_phase;

  assign half     = (n_i + NW'(1)) >> 1;
  assign even_n   = {n_i[NW-1:1], 1'b0};
  assign hi_phase = pos_i < half;
  assign rate_cnt = n_i - pos_i;
  assign sq_hi    = even_n - {pos_i[NW-2:0], 1'b0};
  assign sq_lo    = even_n - {pos_i[NW-2:0] - half[NW-2:0], 1'b0};

  always_comb begin
    out_o   = idle_level(mode_i);
    count_o = cnt_i;
    if (running_i) begin
      unique case (mode_i)
        M_TC_IRQ, M_ONESHOT:       out_o = done_i;
        M_SW_STROBE, M_HW_STROBE:  out_o = strobe_i;
        M_RATE: begin
          out_o   = ~wrap_i;
          count_o = rate_cnt[W-1:0];
        end
        M_SQUARE: begin
          out_o   = hi_phase;
          count_o = hi_phase ? sq_hi[W-1:0] : sq_lo[W-1:0];
        end
        default: out_o = 1'b0;
      endcase
    end
  end

  // R5: strobe only while a one-time terminal pass is recorded
  a_r5_strobe_after_tc: assert final (!(strobe_i && !done_i));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             mode_we_i,
  input  logic [2:0]       mode_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o,
  output logic [2:0]       mode_o,
  output logic             gate_o
);

  mode_e            mode_q;
  logic             running, start, count_en;
  logic [CNT_W:0]   n_val, pos_val;
  logic [CNT_W-1:0] cnt_val;
  logic             done, strobe, wrap;

  pit_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .gate_i     (gate_i),
    .mode_we_i  (mode_we_i),
    .mode_i     (mode_i),
    .load_we_i  (load_we_i),
    .mode_o     (mode_q),
    .gate_o     (gate_o),
    .running_o  (running),
    .start_o    (start),
    .count_en_o (count_en)
  );

  pit_core #(.W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_we_i  (load_we_i),
    .load_val_i (load_val_i),
    .start_i    (start),
    .mode_we_i  (mode_we_i),
    .count_en_i (count_en),
    .hold_val_i (count_o),
    .n_o        (n_val),
    .cnt_o      (cnt_val),
    .pos_o      (pos_val),
    .done_o     (done),
    .strobe_o   (strobe),
    .wrap_o     (wrap)
  );

  pit_shaper #(.W(CNT_W)) u_shape (
    .mode_i    (mode_q),
    .running_i (running),
    .n_i       (n_val),
    .cnt_i     (cnt_val),
    .pos_i     (pos_val),
    .done_i    (done),
    .strobe_i  (strobe),
    .wrap_i    (wrap),
    .out_o     (out_o),
    .count_o   (count_o)
  );

  assign mode_o = mode_q;

  logic one_shot_m, strobe_m, down_m;
  assign one_shot_m = (mode_o == 3'd0) || (mode_o == 3'd1);
  assign strobe_m   = (mode_o == 3'd4) || (mode_o == 3'd5);
  assign down_m     = one_shot_m || strobe_m;

  a_r12_load_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i && !mode_we_i && (mode_o != 3'd3) |=> (count_o == $past(load_val_i)));

  a_r2_out_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    one_shot_m && out_o && !start && !mode_we_i |=> out_o);

  a_r7_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i && !load_we_i |=> (out_o == ((mode_o == 3'd2) || (mode_o == 3'd3))));

  a_r8_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'd0) || (mode_o == 3'd4)) && !gate_i && !load_we_i && !mode_we_i
    |=> $stable(count_o));

  a_r5_pulse_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_m && $rose(out_o) |-> (count_o == '0));

  a_r6_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_m && count_en |=> (count_o == $past(count_o) - CNT_W'(1)));

endmodule

// File: tb/sim_pit_channel.sv
module sim_pit_channel;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0, gate = 1'b1, mode_we = 1'b0, load_we = 1'b0;
  logic [2:0]  mode_v = '0;
  logic [15:0] load_v = '0;
  logic [15:0] count_o;
  logic        out_o, gate_o;
  logic [2:0]  mode_o;

  always #10 clk = ~clk;

  pit_channel u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .gate_i(gate),
    .mode_we_i(mode_we), .mode_i(mode_v), .load_we_i(load_we), .load_val_i(load_v),
    .count_o(count_o), .out_o(out_o), .mode_o(mode_o), .gate_o(gate_o)
  );

  typedef struct {
    int          req;
    logic [15:0] cnt;
    logic        out;
    logic [2:0]  mode;
    logic        gate;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model, elapsed-tick based
  int     m_mode = 0;
  longint m_n = 65536, d = 0;
  bit     m_run = 0, m_gprev = 0;
  int     m_hold = 0;

  function automatic longint m_cnt();
    longint p, h, e;
    if (!m_run) return m_hold;
    p = d % m_n; h = (m_n + 1) / 2; e = m_n - (m_n % 2);
    case (m_mode)
      2: return (m_n - p) & 65535;
      3: return ((p < h) ? (e - 2*p) : (e - 2*(p - h))) & 65535;
      default: return (m_n - d) & 65535;
    endcase
  endfunction

  function automatic bit m_out();
    longint p;
    if (!m_run) return (m_mode == 2 || m_mode == 3);
    p = d % m_n;
    case (m_mode)
      0, 1: return d >= m_n;
      2: return !(p == 0 && d != 0);
      3: return p < (m_n + 1) / 2;
      default: return d == m_n;
    endcase
  endfunction

  task automatic drive(int req, bit tk, bit g, bit mwe, int mv, bit lwe, int lv);
    exp_t e;
    bit rise;
    @(negedge clk);
    tick = tk; gate = g; mode_we = mwe; mode_v = mv[2:0]; load_we = lwe; load_v = lv[15:0];
    rise = g && !m_gprev;
    if (mwe) begin
      m_hold = int'(m_cnt());
      m_mode = (mv >= 6) ? mv - 4 : mv;
    end
    if (lwe) begin
      m_n = (lv == 0) ? 65536 : lv; d = 0; m_run = 1;
    end else if (mwe) m_run = 0;
    else if (m_run && rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) d = 0;
    else if (m_run && tk && (g || !(m_mode == 0 || m_mode == 4))) d++;
    m_gprev = g;
    e.req = req; e.cnt = 16'(m_cnt()); e.out = m_out(); e.mode = 3'(m_mode); e.gate = g;
    q.push_back(e);
  endtask

  task automatic run(int req, int n, bit tk, bit g);
    for (int i = 0; i < n; i++) drive(req, tk, g, 0, 0, 0, 0);
  endtask

  task automatic set_mode(int req, int mv);
    drive(req, 0, gate, 1, mv, 0, 0);
  endtask

  task automatic load(int req, int lv);
    drive(req, 0, gate, 0, 0, 1, lv);
  endtask

  // monitor: compares after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (count_o !== e.cnt || out_o !== e.out || mode_o !== e.mode || gate_o !== e.gate) begin
          n_fail++;
          $display("FAIL R%0d: cnt=%0h out=%0b mode=%0d gate=%0b expected cnt=%0h out=%0b mode=%0d gate=%0b",
                   e.req, count_o, out_o, mode_o, gate_o, e.cnt, e.out, e.mode, e.gate);
        end
      end
    end
  end

  initial begin
    #(150000 * 20);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while held in reset
    n_chk++;
    if (count_o !== 16'h0 || out_o !== 1'b0 || mode_o !== 3'd0) begin
      n_fail++;
      $display("FAIL R1: cnt=%0h out=%0b mode=%0d expected cnt=0 out=0 mode=0", count_o, out_o, mode_o);
    end
    rst_ni = 1'b1;
    run(1, 3, 1, 1);                       // R1: no counting before a load

    // R2 / R6 / R12: mode 0, N=5, then wrap
    set_mode(7, 0);
    load(12, 5);
    run(2, 5, 1, 1);
    run(6, 4, 1, 1);
    // R8: gate low suspends, then resumes
    run(8, 4, 1, 0);
    run(8, 3, 1, 1);

    // R2 / R9: mode 1 one-shot with retrigger
    set_mode(7, 1);
    load(12, 4);
    run(2, 2, 1, 1);
    run(9, 1, 1, 0);
    run(9, 1, 1, 1);
    run(2, 7, 1, 1);

    // R3: rate generator, dense then sparse ticks, then restart
    set_mode(7, 2);
    load(12, 3);
    run(3, 10, 1, 1);
    for (int i = 0; i < 8; i++) drive(3, i[0], 1, 0, 0, 0, 0);
    run(9, 1, 1, 0);
    run(9, 1, 1, 1);
    run(3, 5, 1, 1);

    // R4: square wave even N, then odd N through alias 7 (R11)
    set_mode(7, 3);
    load(12, 6);
    run(4, 14, 1, 1);
    set_mode(11, 7);
    load(4, 5);
    run(4, 12, 1, 1);
    run(9, 1, 1, 0);
    run(9, 3, 1, 1);

    // R5: software strobe, then hardware strobe with restart
    set_mode(7, 4);
    load(12, 3);
    run(5, 6, 1, 1);
    run(8, 2, 1, 0);
    set_mode(7, 5);
    load(12, 2);
    run(5, 4, 1, 1);
    run(9, 1, 1, 0);
    run(9, 4, 1, 1);

    // R7: mode write mid-run holds count and forces idle level
    set_mode(7, 0);
    load(12, 9);
    run(6, 3, 1, 1);
    set_mode(7, 3);
    run(7, 3, 1, 1);
    set_mode(7, 4);
    run(7, 2, 1, 1);

    // R11: code 6 acts as rate generator
    set_mode(11, 6);
    load(11, 2);
    run(11, 5, 1, 1);

    // R10: zero load means 65536 ticks
    set_mode(7, 0);
    load(10, 0);
    run(10, 65540, 1, 1);

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule